// File: doc/BRIEF.md
# Predicate Mask Lookup Unit

This block turns a register operand into a per-element predicate mask for a vector loop. It holds two small predicate tables: one for integer operands and one for floating-point operands. Each table is indexed by the 5-bit architectural register number. An entry holds an enable bit, a 6-bit index of the integer register that supplies the mask, an invert bit and a zeroing bit.

On a lookup, the unit first checks the remap-enable bit, which the neighbouring register-remap stage supplies for the same operand. It then checks the predicate entry. Only when both are enabled is the named integer register read, through a combinational register-file read port, and its value (or its complement) returned as the mask. In every other case the mask is all ones and zeroing is off. The vector length is bounded by XLEN, the number of mask bits.

For a given element offset the unit also gives a per-element enable, which is the matching mask bit. It passes the element's operand register index through when that bit is set and forces the index to zero when it is clear. The tables are programmed through a single-entry write port.

Top module: `pred_mask_unit`

## Requirements
- R1: Two independent tables exist. `lk_fp_i`=0 selects the integer table and `lk_fp_i`=1 selects the floating-point table. `cfg_fp_i` uses the same encoding to choose the table written. A write to one table never changes the result of a lookup in the other.
- R2: When `remap_active_i` is 0, `mask_o` is all ones and `zeroing_o` is 0, whatever the table holds.
- R3: When `remap_active_i` is 1 and the selected entry's enable bit is 0, `mask_o` is all ones and `zeroing_o` is 0.
- R4: When `remap_active_i` is 1 and the selected entry is enabled, `rf_raddr_o` equals the entry's source index. If the invert bit is 0, `mask_o` equals `rf_rdata_i` in the same cycle.
- R5: When the entry is enabled and its invert bit is 1, `mask_o` is the bitwise complement of `rf_rdata_i`.
- R6: When the entry is enabled (with `remap_active_i` at 1), `zeroing_o` equals the entry's zeroing bit.
- R7: `elem_en_o` equals bit `elem_off_i` of `mask_o`. Offsets run from 0 to XLEN-1.
- R8: `elem_reg_o` equals `elem_reg_i` when `elem_en_o` is 1, and is 0 when `elem_en_o` is 0.
- R9: After reset every entry of both tables is disabled, so every lookup gives an all-ones mask with zeroing off.
- R10: A write with `cfg_we_i` at 1 stores {`cfg_active_i`, `cfg_ridx_i`, `cfg_inv_i`, `cfg_zero_i`} at `cfg_idx_i` on the rising clock edge. A lookup sees the old entry before that edge and the new entry after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Table write strobe |
| cfg_fp_i | input | 1 | Table chosen for the write (0 integer, 1 FP) |
| cfg_idx_i | input | $clog2(NREG) | Entry written |
| cfg_active_i | input | 1 | Enable bit written |
| cfg_ridx_i | input | 6 | Source register index written |
| cfg_inv_i | input | 1 | Invert bit written |
| cfg_zero_i | input | 1 | Zeroing bit written |
| lk_fp_i | input | 1 | Table chosen for the lookup (0 integer, 1 FP) |
| lk_idx_i | input | $clog2(NREG) | Operand register number looked up |
| remap_active_i | input | 1 | Remap-enable bit of the operand |
| rf_raddr_o | output | 6 | Integer register-file read address |
| rf_rdata_i | input | XLEN | Integer register-file read data |
| elem_off_i | input | $clog2(XLEN) | Element offset within the loop |
| elem_reg_i | input | 6 | Operand register index of the element |
| mask_o | output | XLEN | Predicate mask |
| zeroing_o | output | 1 | Zeroing flag |
| elem_en_o | output | 1 | Enable for the element at `elem_off_i` |
| elem_reg_o | output | 6 | Element register index, 0 when disabled |

## Verification
The bench builds the unit with XLEN=16 and NREG=32. The narrow mask puts the top element offset (15) and the full-width complement within reach of a short vector table. The full-depth tables let entry 0 and entry 31 of both tables be programmed and looked up side by side. A small model of the register file returns a distinct, non-trivial value for each of the 64 indices. Because of that, a wrong source index, a missing inversion or a swapped table changes the mask in bits that are visible at the ports.

// File: rtl/pred_pkg.sv
package pred_pkg;
  localparam int unsigned ENT_RIDX_W = 6;

  typedef enum logic {
    TBL_INT = 1'b0,
    TBL_FP  = 1'b1
  } tbl_sel_e;

  typedef struct packed {
    logic                  active;
    logic [ENT_RIDX_W-1:0] ridx;
    logic                  inv;
    logic                  zero;
  } pred_ent_t;

  localparam pred_ent_t ENT_RESET = '{active: 1'b0, ridx: '0, inv: 1'b0, zero: 1'b0};
endpackage

// File: rtl/pred_table.sv
module pred_table #(
  parameter int unsigned NREG  = 32,
  localparam int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    waddr_i,
  input  pred_pkg::pred_ent_t wdata_i,
  input  logic [IDX_W-1:0]    raddr_i,
  output pred_pkg::pred_ent_t rdata_o
);
  pred_pkg::pred_ent_t ent_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_ent
    logic hit;
    assign hit = we_i && (waddr_i == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[g] <= pred_pkg::ENT_RESET;
      end else if (hit) begin
        ent_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = ent_q[raddr_i];
endmodule

// File: rtl/pred_mask_gen.sv
module pred_mask_gen #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned RIDX_W = pred_pkg::ENT_RIDX_W
) (
  input  logic                remap_active_i,
  input  pred_pkg::pred_ent_t ent_i,
  output logic [RIDX_W-1:0]   raddr_o,
  input  logic [XLEN-1:0]     rdata_i,
  output logic [XLEN-1:0]     mask_o,
  output logic                zeroing_o
);
  logic pred_on;

  // both levels must be enabled, otherwise the mask is unconditional
  assign pred_on = remap_active_i && ent_i.active;
  assign raddr_o = ent_i.ridx;

  always_comb begin
    mask_o    = '1;
    zeroing_o = 1'b0;
    if (pred_on) begin
      mask_o    = ent_i.inv ? ~rdata_i : rdata_i;
      zeroing_o = ent_i.zero;
    end
  end
endmodule

// File: rtl/pred_elem_gate.sv
module pred_elem_gate #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned RIDX_W = pred_pkg::ENT_RIDX_W,
  localparam int unsigned OFF_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]   mask_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [RIDX_W-1:0] reg_i,
  output logic              en_o,
  output logic [RIDX_W-1:0] reg_o
);
  assign en_o  = mask_i[off_i];
  assign reg_o = en_o ? reg_i : '0;
endmodule

// File: rtl/pred_mask_unit.sv
module pred_mask_unit #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NREG  = 32,
  localparam int unsigned IDX_W  = $clog2(NREG),
  localparam int unsigned OFF_W  = $clog2(XLEN),
  localparam int unsigned RIDX_W = pred_pkg::ENT_RIDX_W,
  localparam int unsigned NTBL   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic              cfg_fp_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic              cfg_active_i,
  input  logic [RIDX_W-1:0] cfg_ridx_i,
  input  logic              cfg_inv_i,
  input  logic              cfg_zero_i,
  input  logic              lk_fp_i,
  input  logic [IDX_W-1:0]  lk_idx_i,
  input  logic              remap_active_i,
  output logic [RIDX_W-1:0] rf_raddr_o,
  input  logic [XLEN-1:0]   rf_rdata_i,
  input  logic [OFF_W-1:0]  elem_off_i,
  input  logic [RIDX_W-1:0] elem_reg_i,
  output logic [XLEN-1:0]   mask_o,
  output logic              zeroing_o,
  output logic              elem_en_o,
  output logic [RIDX_W-1:0] elem_reg_o
);
  import pred_pkg::*;

  pred_ent_t wr_ent;
  pred_ent_t tbl_rd [NTBL];
  pred_ent_t sel_ent;

  assign wr_ent = '{active: cfg_active_i, ridx: cfg_ridx_i, inv: cfg_inv_i, zero: cfg_zero_i};

  // R1: one table per register class
  for (genvar t = 0; t < NTBL; t++) begin : g_tbl
    logic tbl_we;
    assign tbl_we = cfg_we_i && (tbl_sel_e'(cfg_fp_i) == tbl_sel_e'(t));
    pred_table #(.NREG(NREG)) u_tbl (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (tbl_we),
      .waddr_i(cfg_idx_i),
      .wdata_i(wr_ent),
      .raddr_i(lk_idx_i),
      .rdata_o(tbl_rd[t])
    );
  end

  assign sel_ent = (tbl_sel_e'(lk_fp_i) == TBL_FP) ? tbl_rd[1] : tbl_rd[0];

  pred_mask_gen #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_gen (
    .remap_active_i(remap_active_i),
    .ent_i         (sel_ent),
    .raddr_o       (rf_raddr_o),
    .rdata_i       (rf_rdata_i),
    .mask_o        (mask_o),
    .zeroing_o     (zeroing_o)
  );

  pred_elem_gate #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_gate (
    .mask_i(mask_o),
    .off_i (elem_off_i),
    .reg_i (elem_reg_i),
    .en_o  (elem_en_o),
    .reg_o (elem_reg_o)
  );
endmodule

// File: rtl/pred_mask_unit_chk.sv
module pred_mask_unit_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned NREG = 32,
  localparam int unsigned IDX_W  = $clog2(NREG),
  localparam int unsigned OFF_W  = $clog2(XLEN),
  localparam int unsigned RIDX_W = pred_pkg::ENT_RIDX_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                cfg_we_i,
  input logic                cfg_fp_i,
  input logic [IDX_W-1:0]    cfg_idx_i,
  input pred_pkg::pred_ent_t wr_ent_i,
  input logic                lk_fp_i,
  input logic [IDX_W-1:0]    lk_idx_i,
  input logic                remap_active_i,
  input pred_pkg::pred_ent_t sel_ent_i,
  input logic [RIDX_W-1:0]   rf_raddr_i,
  input logic [XLEN-1:0]     rf_rdata_i,
  input logic [OFF_W-1:0]    elem_off_i,
  input logic [RIDX_W-1:0]   elem_reg_i,
  input logic [XLEN-1:0]     mask_i,
  input logic                zeroing_i,
  input logic                elem_en_i,
  input logic [RIDX_W-1:0]   elem_reg_o_i
);
  // R2
  remap_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !remap_active_i |-> (mask_i == '1) && !zeroing_i);

  // R3
  pred_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_active_i && !sel_ent_i.active) |-> (mask_i == '1) && !zeroing_i);

  // R4
  mask_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_active_i && sel_ent_i.active && !sel_ent_i.inv)
      |-> (rf_raddr_i == sel_ent_i.ridx) && (mask_i == rf_rdata_i));

  // R5
  mask_inv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_active_i && sel_ent_i.active && sel_ent_i.inv) |-> (mask_i == ~rf_rdata_i));

  // R6
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remap_active_i && sel_ent_i.active) |-> (zeroing_i == sel_ent_i.zero));

  // R7
  elem_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elem_en_i == mask_i[elem_off_i]);

  // R8
  elem_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !elem_en_i |-> (elem_reg_o_i == '0));

  // R8
  elem_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elem_en_i |-> (elem_reg_o_i == elem_reg_i));

  // R10
  wr_vis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(cfg_we_i) && ($past(cfg_fp_i) == lk_fp_i) &&
     ($past(cfg_idx_i) == lk_idx_i)) |-> (sel_ent_i == $past(wr_ent_i)));
endmodule

bind pred_mask_unit pred_mask_unit_chk #(.XLEN(XLEN), .NREG(NREG)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_we_i      (cfg_we_i),
  .cfg_fp_i      (cfg_fp_i),
  .cfg_idx_i     (cfg_idx_i),
  .wr_ent_i      (wr_ent),
  .lk_fp_i       (lk_fp_i),
  .lk_idx_i      (lk_idx_i),
  .remap_active_i(remap_active_i),
  .sel_ent_i     (sel_ent),
  .rf_raddr_i    (rf_raddr_o),
  .rf_rdata_i    (rf_rdata_i),
  .elem_off_i    (elem_off_i),
  .elem_reg_i    (elem_reg_i),
  .mask_i        (mask_o),
  .zeroing_i     (zeroing_o),
  .elem_en_i     (elem_en_o),
  .elem_reg_o_i  (elem_reg_o)
);

// File: tb/pred_mask_unit_bench.sv
module pred_mask_unit_bench;
  localparam int unsigned B_XLEN = 16;
  localparam int unsigned B_NREG = 32;
  localparam int unsigned B_OFFW = 4;
  localparam int unsigned NVEC   = 16;

  // vector: [15] fp, [14:10] idx, [9] remap, [3:0] offset
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b0, 5'd1,  1'b1, 5'd0, 4'd0},
    {1'b0, 5'd1,  1'b1, 5'd0, 4'd7},
    {1'b0, 5'd2,  1'b1, 5'd0, 4'd3},
    {1'b0, 5'd2,  1'b1, 5'd0, 4'd15},
    {1'b0, 5'd3,  1'b1, 5'd0, 4'd5},
    {1'b0, 5'd31, 1'b1, 5'd0, 4'd9},
    {1'b0, 5'd1,  1'b0, 5'd0, 4'd4},
    {1'b1, 5'd1,  1'b1, 5'd0, 4'd2},
    {1'b1, 5'd1,  1'b1, 5'd0, 4'd15},
    {1'b1, 5'd4,  1'b1, 5'd0, 4'd4},
    {1'b1, 5'd4,  1'b1, 5'd0, 4'd0},
    {1'b1, 5'd2,  1'b1, 5'd0, 4'd6},
    {1'b1, 5'd4,  1'b0, 5'd0, 4'd4},
    {1'b0, 5'd0,  1'b1, 5'd0, 4'd1},
    {1'b1, 5'd31, 1'b1, 5'd0, 4'd12},
    {1'b0, 5'd2,  1'b0, 5'd0, 4'd11}
  };

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              cfg_we_i = 1'b0;
  logic              cfg_fp_i = 1'b0;
  logic [4:0]        cfg_idx_i = '0;
  logic              cfg_active_i = 1'b0;
  logic [5:0]        cfg_ridx_i = '0;
  logic              cfg_inv_i = 1'b0;
  logic              cfg_zero_i = 1'b0;
  logic              lk_fp_i = 1'b0;
  logic [4:0]        lk_idx_i = '0;
  logic              remap_active_i = 1'b0;
  logic [5:0]        rf_raddr_o;
  logic [B_XLEN-1:0] rf_rdata_i;
  logic [B_OFFW-1:0] elem_off_i = '0;
  logic [5:0]        elem_reg_i = '0;
  logic [B_XLEN-1:0] mask_o;
  logic              zeroing_o;
  logic              elem_en_o;
  logic [5:0]        elem_reg_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic       sh_act  [2][B_NREG];
  logic [5:0] sh_ridx [2][B_NREG];
  logic       sh_inv  [2][B_NREG];
  logic       sh_zero [2][B_NREG];

  always #5 clk_i = ~clk_i;

  function automatic logic [B_XLEN-1:0] rf_val(input logic [5:0] a);
    return B_XLEN'(16'(a) * 16'h3B1D + 16'h5A0F);
  endfunction

  assign rf_rdata_i = rf_val(rf_raddr_o);

  pred_mask_unit #(.XLEN(B_XLEN), .NREG(B_NREG)) u_pred_mask_unit (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_fp_i(cfg_fp_i), .cfg_idx_i(cfg_idx_i),
    .cfg_active_i(cfg_active_i), .cfg_ridx_i(cfg_ridx_i),
    .cfg_inv_i(cfg_inv_i), .cfg_zero_i(cfg_zero_i),
    .lk_fp_i(lk_fp_i), .lk_idx_i(lk_idx_i), .remap_active_i(remap_active_i),
    .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
    .elem_off_i(elem_off_i), .elem_reg_i(elem_reg_i),
    .mask_o(mask_o), .zeroing_o(zeroing_o),
    .elem_en_o(elem_en_o), .elem_reg_o(elem_reg_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic shadow_clear();
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < B_NREG; i++) begin
        sh_act[t][i] = 1'b0; sh_ridx[t][i] = '0; sh_inv[t][i] = 1'b0; sh_zero[t][i] = 1'b0;
      end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    shadow_clear();
    @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  task automatic wr(input logic fp, input logic [4:0] idx, input logic act,
                    input logic [5:0] ridx, input logic inv, input logic zero);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_fp_i = fp; cfg_idx_i = idx;
    cfg_active_i = act; cfg_ridx_i = ridx; cfg_inv_i = inv; cfg_zero_i = zero;
    @(posedge clk_i);
    #1 cfg_we_i = 1'b0;
    sh_act[fp][idx] = act; sh_ridx[fp][idx] = ridx;
    sh_inv[fp][idx] = inv; sh_zero[fp][idx] = zero;
  endtask

  // compares all outputs against the shadow model; req names the requirement under test
  task automatic look(input logic fp, input logic [4:0] idx, input logic remap,
                      input logic [B_OFFW-1:0] off, input logic [5:0] ereg, input string req);
    logic on;
    logic [B_XLEN-1:0] m;
    logic z, en;
    @(negedge clk_i);
    lk_fp_i = fp; lk_idx_i = idx; remap_active_i = remap;
    elem_off_i = off; elem_reg_i = ereg;
    #2;
    on = remap && sh_act[fp][idx];
    m  = on ? (sh_inv[fp][idx] ? ~rf_val(sh_ridx[fp][idx]) : rf_val(sh_ridx[fp][idx])) : '1;
    z  = on && sh_zero[fp][idx];
    en = m[off];
    if (on) chk(rf_raddr_o == sh_ridx[fp][idx], {req, " R4 raddr"}, 32'(rf_raddr_o), 32'(sh_ridx[fp][idx]));
    chk(mask_o == m, {req, " mask"}, 32'(mask_o), 32'(m));
    chk(zeroing_o == z, {req, " R6 zeroing"}, 32'(zeroing_o), 32'(z));
    chk(elem_en_o == en, {req, " R7 elem_en"}, 32'(elem_en_o), 32'(en));
    chk(elem_reg_o == (en ? ereg : 6'd0), {req, " R8 elem_reg"}, 32'(elem_reg_o), 32'(en ? ereg : 6'd0));
  endtask

  initial begin
    shadow_clear();
    do_reset();

    // R9: reset leaves both tables disabled
    for (int i = 0; i < B_NREG; i += 5) begin
      look(1'b0, 5'(i), 1'b1, 4'd3, 6'd9, "R9 int");
      look(1'b1, 5'(i), 1'b1, 4'd14, 6'd9, "R9 fp");
    end

    wr(1'b0, 5'd1,  1'b1, 6'd10, 1'b0, 1'b1);
    wr(1'b0, 5'd2,  1'b1, 6'd40, 1'b1, 1'b0);
    wr(1'b0, 5'd3,  1'b0, 6'd7,  1'b1, 1'b1);
    wr(1'b0, 5'd31, 1'b1, 6'd5,  1'b0, 1'b1);
    wr(1'b1, 5'd1,  1'b1, 6'd63, 1'b1, 1'b1);
    wr(1'b1, 5'd4,  1'b1, 6'd0,  1'b0, 1'b0);
    wr(1'b1, 5'd31, 1'b1, 6'd33, 1'b1, 1'b0);
    wr(1'b0, 5'd0,  1'b1, 6'd21, 1'b0, 1'b0);

    // R1 R2 R3 R4 R5 vector walk
    for (int v = 0; v < NVEC; v++)
      look(VEC[v][15], VEC[v][14:10], VEC[v][9], VEC[v][3:0], 6'(v + 1), "R1/R2/R3/R4/R5 vec");

    // R1: fp table slot 2 and int slot 4 untouched by writes to the other table
    look(1'b1, 5'd2, 1'b1, 4'd0, 6'd3, "R1 fp-iso");
    look(1'b0, 5'd4, 1'b1, 4'd0, 6'd3, "R1 int-iso");
    // R3: disabled int entry with set inv/zero bits
    look(1'b0, 5'd3, 1'b1, 4'd4, 6'd12, "R3");
    // R2: remap off on enabled inverted entry
    look(1'b0, 5'd2, 1'b0, 4'd15, 6'd12, "R2");
    // R5: full-width complement at top offset
    look(1'b0, 5'd2, 1'b1, 4'd15, 6'd44, "R5");
    // R8: fp idx4 mask 0x5A0F has bit 4 clear -> element killed
    look(1'b1, 5'd4, 1'b1, 4'd4, 6'd55, "R8 kill");
    chk(elem_reg_o == 6'd0, "R8 killed elem", 32'(elem_reg_o), 32'd0);

    // R10: new entry invisible before the edge, visible after
    @(negedge clk_i);
    lk_fp_i = 1'b1; lk_idx_i = 5'd9; remap_active_i = 1'b1; elem_off_i = 4'd0;
    cfg_we_i = 1'b1; cfg_fp_i = 1'b1; cfg_idx_i = 5'd9;
    cfg_active_i = 1'b1; cfg_ridx_i = 6'd12; cfg_inv_i = 1'b0; cfg_zero_i = 1'b1;
    #2;
    chk(mask_o == '1, "R10 before edge", 32'(mask_o), 32'hFFFF);
    @(posedge clk_i);
    #1 cfg_we_i = 1'b0;
    #1;
    chk(mask_o == rf_val(6'd12), "R10 after edge", 32'(mask_o), 32'(rf_val(6'd12)));
    chk(zeroing_o == 1'b1, "R10 zero after edge", 32'(zeroing_o), 32'd1);
    sh_act[1][9] = 1'b1; sh_ridx[1][9] = 6'd12; sh_zero[1][9] = 1'b1; sh_inv[1][9] = 1'b0;
    look(1'b0, 5'd9, 1'b1, 4'd0, 6'd1, "R10/R1 other table");

    // R9: second reset clears programmed entries
    do_reset();
    look(1'b0, 5'd1, 1'b1, 4'd2, 6'd7, "R9 after re-reset");
    look(1'b1, 5'd1, 1'b1, 4'd2, 6'd7, "R9 after re-reset");

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    end
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule